// File: doc/BRIEF.md
# Four-Bank Interleaved Line-Fill Memory

This block serves cache-line refills from a main memory split into four word-wide banks. A requester presents a line address on a valid/ready port. The controller spends a fixed address phase on the request and then waits a fixed bank access time. It then streams the line back one word per cycle, tagging each word with its index and flagging the final word. Word address `4*line + w` maps to bank `w`, because the bank number is taken from the two low bits of the word address. As a result, the four words of a line always sit in four different banks.

A build parameter chooses between two organizations. In interleaved mode, one address phase starts all four banks together. Once the access time has elapsed, the four words leave on four back-to-back cycles. In word-sequential mode, every word repeats the full address, access and transfer sequence. This lets the two organizations be compared on the same stimulus. Every completed line leaves its total cycle count on a latency output. A simple write port preloads the banks.

Top module: `line_fill_mem`

## Requirements
- R1: After synchronous reset, and during the first cycle after reset is released, `req_ready` is 1, `out_valid` is 0 and `lat_cycles` is 0. This also holds when reset hits in the middle of a line.
- R2: A preload write to word address A stores `pre_data` in bank A[1:0] at row A[7:2]. Line L, word w, is read back from word address 4*L + w.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the line's last word has been shown. Requests presented during that time are ignored and do not change the words returned.
- R4: In interleaved mode (default timing: address phase 1 cycle, access 4 cycles), word w is shown with `out_valid` = 1 and `out_idx` = w in cycle 6 + w. Cycle 1 is the cycle after the accepting edge. No other cycle has `out_valid` high.
- R5: In word-sequential mode, word w is shown in cycle 6*(w+1), each in a single cycle, and `out_valid` is 0 in all other cycles.
- R6: `out_last` is 1 only together with `out_valid` and `out_idx` = 3.
- R7: From the cycle after the last word, `lat_cycles` holds the line's total cycle count: 9 for interleaved and 24 for sequential.
- R8: `out_data` equals the word preloaded at address 4*L + `out_idx`.
- R9: `req_ready` returns to 1 in the cycle right after the last word. A request held valid through the busy period is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request present |
| req_line | input | LINE_AW (6) | Line address of the request |
| req_ready | output | 1 | Controller idle, request will be taken |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | LINE_AW+2 (8) | Preload word address |
| pre_data | input | WORD_W (32) | Preload word |
| out_valid | output | 1 | Returned word valid this cycle |
| out_idx | output | 2 | Index of the returned word in its line |
| out_data | output | WORD_W (32) | Returned word |
| out_last | output | 1 | Returned word is the line's final word |
| lat_cycles | output | 5 | Total cycles of the most recent completed line |

## Verification
Lines are fetched in both organizations from the lowest line, the highest line and scattered middle lines. Each word holds a value derived from its own address, so a wrong bank select, a wrong row or a swapped word order shows up as a data mismatch. Every cycle of a fetch is compared against the exact cycle each word is due. This separates the consecutive four-word burst of the interleaved build from the spaced single words of the sequential build, and it catches early or late phases. Two directed sequences hold a request valid across a busy line and then apply reset in the middle of a line. These confirm that busy-time requests change nothing, that the queued request is taken at once afterwards, and that reset returns the block to idle.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_XFER = 2'd3
  } lfm_state_e;
endpackage

// File: rtl/lfm_bank.sv
module lfm_bank #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ROW_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lfm_ctrl.sv
module lfm_ctrl
  import lfm_pkg::*;
#(
  parameter int LINE_AW     = 6,
  parameter int WORDS       = 4,
  parameter int ADDR_CYC    = 1,
  parameter int ACC_CYC     = 4,
  parameter bit INTERLEAVED = 1'b1,
  parameter int LAT_W       = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [LINE_AW-1:0]       req_line,
  output logic                     req_ready,
  output logic [LINE_AW-1:0]       line_q,
  output logic [WORDS-1:0]         rd_en,
  output logic                     load,
  output logic [$clog2(WORDS)-1:0] load_idx,
  output logic [LAT_W-1:0]         lat_cycles
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int PC_W  = $clog2(ADDR_CYC + ACC_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  lfm_state_e       st;
  logic [PC_W-1:0]  pc;
  logic [IDX_W-1:0] wcnt;
  logic [LAT_W-1:0] cyc;
  logic             addr_end;
  logic             acc_end;

  assign addr_end  = (st == ST_ADDR) && (pc == PC_W'(ADDR_CYC - 1));
  assign acc_end   = (st == ST_ACC)  && (pc == PC_W'(ACC_CYC - 1));
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pc         <= '0;
      wcnt       <= '0;
      line_q     <= '0;
      cyc        <= '0;
      lat_cycles <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st     <= ST_ADDR;
            line_q <= req_line;
            wcnt   <= '0;
            pc     <= '0;
            cyc    <= LAT_W'(1);
          end
        end
        ST_ADDR: begin
          cyc <= cyc + 1'b1;
          if (addr_end) begin
            pc <= '0;
            st <= ST_ACC;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        ST_ACC: begin
          cyc <= cyc + 1'b1;
          if (acc_end) begin
            pc <= '0;
            st <= ST_XFER;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        default: begin
          cyc <= cyc + 1'b1;
          if (wcnt == LAST_IDX) begin
            st         <= ST_IDLE;
            lat_cycles <= cyc;
          end else begin
            wcnt <= wcnt + 1'b1;
            if (!INTERLEAVED) st <= ST_ADDR;
          end
        end
      endcase
    end
  end

  for (genvar b = 0; b < WORDS; b++) begin : g_rd
    if (INTERLEAVED) begin : g_all
      assign rd_en[b] = addr_end;
    end else begin : g_one
      assign rd_en[b] = addr_end && (wcnt == IDX_W'(b));
    end
  end

  assign load     = acc_end ||
                    (INTERLEAVED && (st == ST_XFER) && (wcnt != LAST_IDX));
  assign load_idx = (st == ST_XFER) ? wcnt + 1'b1 : wcnt;

  AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACC) |-> (pc < PC_W'(ACC_CYC))) else $error("pc overrun"); // R4
  AST_LINE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(line_q)) else $error("line moved"); // R3
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    !INTERLEAVED |-> $onehot0(rd_en)) else $error("multi read"); // R5
endmodule

// File: rtl/line_fill_mem.sv
module line_fill_mem #(
  parameter int WORD_W      = 32,
  parameter int LINE_AW     = 6,
  parameter int WORDS       = 4,
  parameter int ADDR_CYC    = 1,
  parameter int ACC_CYC     = 4,
  parameter bit INTERLEAVED = 1'b1,
  localparam int IDX_W      = $clog2(WORDS),
  localparam int WADDR_W    = LINE_AW + IDX_W,
  localparam int LAT_W      = $clog2(WORDS * (ADDR_CYC + ACC_CYC + 1) + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LINE_AW-1:0] req_line,
  output logic               req_ready,
  input  logic               pre_we,
  input  logic [WADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0]  pre_data,
  output logic               out_valid,
  output logic [IDX_W-1:0]   out_idx,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_last,
  output logic [LAT_W-1:0]   lat_cycles
);
  localparam int LINE_LAT = INTERLEAVED ? (ADDR_CYC + ACC_CYC + WORDS)
                                        : (WORDS * (ADDR_CYC + ACC_CYC + 1));
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [LINE_AW-1:0] line_q;
  logic [WORDS-1:0]   rd_en;
  logic               load;
  logic [IDX_W-1:0]   load_idx;
  logic [WORD_W-1:0]  bank_q [WORDS];

  lfm_ctrl #(
    .LINE_AW(LINE_AW), .WORDS(WORDS), .ADDR_CYC(ADDR_CYC),
    .ACC_CYC(ACC_CYC), .INTERLEAVED(INTERLEAVED), .LAT_W(LAT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .req_ready(req_ready), .line_q(line_q), .rd_en(rd_en), .load(load),
    .load_idx(load_idx), .lat_cycles(lat_cycles)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_bank
    lfm_bank #(.WORD_W(WORD_W), .ROW_W(LINE_AW)) u_bank (
      .clk(clk),
      .we(pre_we && (pre_addr[IDX_W-1:0] == IDX_W'(g))),
      .waddr(pre_addr[WADDR_W-1:IDX_W]),
      .wdata(pre_data),
      .re(rd_en[g]),
      .raddr(line_q),
      .rdata(bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= load;
      out_last  <= load && (load_idx == LAST_IDX);
      if (load) begin
        out_idx  <= load_idx;
        out_data <= bank_q[load_idx];
      end
    end
  end

  AST_LAST_IDX: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_idx == LAST_IDX)) else $error("last idx"); // R6
  AST_NO_READY_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready) else $error("ready while busy"); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready) else $error("no busy"); // R3
  AST_LAT_VALUE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> (lat_cycles == LAT_W'(LINE_LAT))) else $error("lat"); // R7
  AST_READY_AFTER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> req_ready) else $error("ready late"); // R9

  if (INTERLEAVED) begin : g_chk_il
    AST_STREAM: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_last) |=>
        (out_valid && out_idx == IDX_W'($past(out_idx) + 1'b1))) else $error("stream"); // R4
  end else begin : g_chk_sq
    AST_GAP: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid) else $error("gap"); // R5
  end
endmodule

// File: tb/tb_line_fill_mem.sv
module tb_line_fill_mem;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        rv;
  logic [5:0]  rl;
  logic        sel_seq;
  logic        pre_we;
  logic [7:0]  pre_addr;
  logic [31:0] pre_data;

  logic        i_ready, i_ov, i_last, s_ready, s_ov, s_last;
  logic [1:0]  i_idx, s_idx;
  logic [31:0] i_data, s_data;
  logic [4:0]  i_lat, s_lat;

  int checks = 0;
  int fails  = 0;

  line_fill_mem #(.INTERLEAVED(1'b1)) dut (
    .clk(clk), .rst(rst), .req_valid(rv && !sel_seq), .req_line(rl),
    .req_ready(i_ready), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .out_valid(i_ov), .out_idx(i_idx), .out_data(i_data), .out_last(i_last),
    .lat_cycles(i_lat)
  );

  line_fill_mem #(.INTERLEAVED(1'b0)) dut_seq (
    .clk(clk), .rst(rst), .req_valid(rv && sel_seq), .req_line(rl),
    .req_ready(s_ready), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .out_valid(s_ov), .out_idx(s_idx), .out_data(s_data), .out_last(s_last),
    .lat_cycles(s_lat)
  );

  function automatic logic [31:0] word_val(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // watch one line; entered at the negedge of cycle 1, leaves at the negedge of cycle N+1
  task automatic watch(input bit sq, input int line);
    int n;
    n = sq ? 24 : 9;
    for (int k = 1; k <= n; k++) begin
      bit   ev;
      int   w;
      logic ov, rdy, lst;
      logic [1:0]  idx;
      logic [31:0] dat;
      ov  = sq ? s_ov : i_ov;
      rdy = sq ? s_ready : i_ready;
      lst = sq ? s_last : i_last;
      idx = sq ? s_idx : i_idx;
      dat = sq ? s_data : i_data;
      if (sq) begin ev = (k % 6 == 0); w = k / 6 - 1; end
      else    begin ev = (k >= 6);     w = k - 6;     end
      chk(rdy == 1'b0, "R3 busy ready", rdy, 0);
      chk(ov == ev, sq ? "R5 valid timing" : "R4 valid timing", ov, ev);
      if (ev && ov) begin
        chk(idx == 2'(w), "R4/R5 index", idx, w);
        chk(dat == word_val(line * 4 + w), "R8 data (R2 map)", dat, word_val(line * 4 + w));
        chk(lst == (w == 3), "R6 last flag", lst, (w == 3));
      end
      @(negedge clk);
    end
    chk((sq ? s_ready : i_ready) == 1'b1, "R9 ready after line", sq ? s_ready : i_ready, 1);
    chk((sq ? s_lat : i_lat) == 5'(n), "R7 latency", sq ? s_lat : i_lat, n);
    chk((sq ? s_ov : i_ov) == 1'b0, "R6 valid off after last", sq ? s_ov : i_ov, 0);
  endtask

  task automatic fetch(input bit sq, input int line);
    sel_seq = sq;
    rl = 6'(line);
    rv = 1'b1;
    while (!(sq ? s_ready : i_ready)) @(negedge clk);
    @(negedge clk);
    rv = 1'b0;
    watch(sq, line);
  endtask

  // {seq, unused, line[5:0]}
  localparam logic [7:0] VEC [10] = '{
    8'h00, 8'h3F, 8'h15, 8'h2A, 8'h07,
    8'h80, 8'hBF, 8'h95, 8'hA2, 8'h81
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; rv = 1'b0; rl = '0; sel_seq = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(i_ready && s_ready, "R1 ready after reset", {i_ready, s_ready}, 3);
    chk(!i_ov && !s_ov, "R1 valid after reset", {i_ov, s_ov}, 0);
    chk(i_lat == 0 && s_lat == 0, "R1 latency after reset", {i_lat, s_lat}, 0);

    // R2 preload every word address
    for (int a = 0; a < 256; a++) begin
      pre_we = 1'b1; pre_addr = 8'(a); pre_data = word_val(a);
      @(negedge clk);
    end
    pre_we = 1'b0;

    for (int v = 0; v < 10; v++) fetch(VEC[v][7], int'(VEC[v][5:0]));

    // R3/R9: request held valid during busy line, queued line taken right after
    sel_seq = 1'b0; rl = 6'd5; rv = 1'b1;
    @(negedge clk);
    rl = 6'd9;
    watch(1'b0, 5);
    @(negedge clk);
    rv = 1'b0;
    watch(1'b0, 9);

    // R1: reset in the middle of a sequential line
    sel_seq = 1'b1; rl = 6'd12; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(s_ready == 1'b1, "R1 ready after mid reset", s_ready, 1);
    chk(s_ov == 1'b0, "R1 valid after mid reset", s_ov, 0);
    chk(s_lat == 0, "R1 latency after mid reset", s_lat, 0);
    fetch(1'b1, 12);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule